// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Controller

This block sits between a serial word receiver and a two-channel converter core. For each strobed 16-bit command word it decides which registers change. The upper four bits of the word are control and the lower twelve are data. Each channel holds a 12-bit staging register and a 12-bit active register. The active register drives the core. Because of this double buffering, software can preload one or both channels and then make them take effect together on a single command.

Data arrives in two's complement. The core needs offset binary, so the block inverts bit 11 of each active code. Through the same command word the block also holds a 2-bit power-down state per channel. The power-on reset and an asynchronous active-low clear both return every register to zero, which is midscale, and both return both channels to normal operation. All register updates take place on the first rising clock edge at which `load` is sampled high.

Top module: `dual_dac_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released, both codes read 12'h800 and both power-down states read 2'b00 (normal). Output codes equal the active register with bit 11 inverted.
- R2: A normal word (bit 12 = 0) with bits 15:14 = 00 writes only the staging register of the channel that bit 13 selects (0 = A, 1 = B). No output changes.
- R3: A normal word with bits 15:14 = 01 writes the data into the staging and active registers of the selected channel. The new code is visible one clock edge after the strobe.
- R4: A normal word with bits 15:14 = 10 writes the selected channel's staging and active registers. In the same cycle it loads the other channel's active register from that channel's own staging register.
- R5: Bits 15:14 = 11 with bit 13 = 0 write the data into the staging and active registers of both channels. Bits 15:14 = 11 with bit 13 = 1 load both active registers from their staging registers and ignore the data.
- R6: A word with bit 12 = 1 sets power-down state without changing any code. Bits 11:10 choose the state: 00 or 11 give hi-Z (output 2'b11), 01 gives a 1 kOhm load (2'b01) and 10 gives a 100 kOhm load (2'b10). Bits 15:14 choose the target: 00 or 11 for both channels, 01 for A only, 10 for B only.
- R7: Any normal command that writes a channel's active register returns that channel's power-down state to 2'b00. A staging-only write leaves the power-down state unchanged.
- R8: Driving `clr_n` low, with no clock edge needed, sets both codes to 12'h800 and both power-down states to 2'b00, and clears both staging registers.
- R9: While no word is strobed, including after `clr_n` is released, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear |
| load | input | 1 | Strobe: the word is acted on at this clock edge |
| word | input | 16 | Command word: control bits 15:12, data bits 11:0 |
| code_a | output | 12 | Offset-binary code for channel A |
| code_b | output | 12 | Offset-binary code for channel B |
| pdm_a | output | 2 | Channel A state: 00 normal, 01 1 kOhm, 10 100 kOhm, 11 hi-Z |
| pdm_b | output | 2 | Channel B state, same encoding |

## Verification
Every command result appears at the rising edge that samples `load`. The bench drives each word at a falling edge, drops the strobe just after the following rising edge, and queues the expected outputs. The monitor compares them at the next falling edge, half a cycle after they are due. Clear takes effect without a clock, so it is also checked 2 ns after `clr_n` falls, before any edge occurs. Idle cycles queue the unchanged model state, which shows that outputs hold when no strobe arrives.

// File: rtl/dual_dac_regs.sv
module dual_dac_regs #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          load,
  input  logic [DW+3:0] word,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b,
  output logic [1:0]    pdm_a,
  output logic [1:0]    pdm_b
);
  localparam logic [DW-1:0] MSB = {1'b1, {(DW-1){1'b0}}};

  wire          pd_cmd = word[DW];
  wire          sel    = word[DW+1];
  wire [1:0]    op     = word[DW+3:DW+2];
  wire [DW-1:0] din    = word[DW-1:0];
  wire [1:0]    imp_f  = word[DW-1:DW-2];
  wire [1:0]    imp    = (imp_f == 2'b00) ? 2'b11 : imp_f;
  wire          nrm    = load && !pd_cmd;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic [DW-1:0] stg, act;
    logic [1:0]    pdm;
    wire mine = (sel == 1'(i));
    wire take = nrm && ((op != 2'b11 && mine) || (op == 2'b11 && !sel));
    wire put  = take && (op != 2'b00);
    wire xfer = nrm && ((op == 2'b10 && !mine) || (op == 2'b11 && sel));
    wire pds  = load && pd_cmd && (op == 2'b00 || op == 2'b11 || op == 2'(1 << i));

    always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
      if (!rst_n || !clr_n) begin
        stg <= '0;
        act <= '0;
        pdm <= 2'b00;
      end else begin
        if (take) stg <= din;
        if (put) act <= din;
        else if (xfer) act <= stg;
        if (put || xfer) pdm <= 2'b00;
        else if (pds) pdm <= imp;
      end
    end
  end

  assign code_a = g_ch[0].act ^ MSB;
  assign code_b = g_ch[1].act ^ MSB;
  assign pdm_a  = g_ch[0].pdm;
  assign pdm_b  = g_ch[1].pdm;
endmodule

// File: rtl/dual_dac_regs_chk.sv
module dual_dac_regs_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_n,
  input logic          load,
  input logic [DW+3:0] word,
  input logic [DW-1:0] code_a,
  input logic [DW-1:0] code_b,
  input logic [1:0]    pdm_a,
  input logic [1:0]    pdm_b
);
  localparam logic [DW-1:0] MSB = {1'b1, {(DW-1){1'b0}}};

  AST_STAGE_ONLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    load && !word[DW] && word[DW+3:DW+2] == 2'b00 |=>
      $stable(code_a) && $stable(code_b) && $stable(pdm_a) && $stable(pdm_b)); // R2

  AST_UPDATE_A_CODE: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    load && !word[DW] && word[DW+3:DW+1] == 3'b010 |=>
      code_a == ($past(word[DW-1:0]) ^ MSB)); // R3

  AST_UPDATE_A_WAKES: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    load && !word[DW] && word[DW+3:DW+1] == 3'b010 |=> pdm_a == 2'b00); // R7

  AST_PD_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    load && word[DW] |=> $stable(code_a) && $stable(code_b)); // R6

  AST_PD_B_1K: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    load && word[DW+3:DW] == 4'b1001 && word[DW-1:DW-2] == 2'b01 |=>
      pdm_b == 2'b01 && $stable(pdm_a)); // R6

  AST_CLEAR_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> code_a == MSB && code_b == MSB && pdm_a == 2'b00 && pdm_b == 2'b00); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !load |=> $stable(code_a) && $stable(code_b) && $stable(pdm_a) && $stable(pdm_b)); // R9
endmodule

bind dual_dac_regs dual_dac_regs_chk #(.DW(DW)) u_chk (.*);

// File: tb/dual_dac_regs_bench.sv
`timescale 1ns/1ps
module dual_dac_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_n = 1'b1;
  logic        load = 1'b0;
  logic [15:0] word = '0;
  logic [11:0] code_a, code_b;
  logic [1:0]  pdm_a, pdm_b;

  dual_dac_regs u_dual_dac_regs (.clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load(load),
    .word(word), .code_a(code_a), .code_b(code_b), .pdm_a(pdm_a), .pdm_b(pdm_b));

  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  logic [11:0] m_stg [2];
  logic [11:0] m_act [2];
  logic [1:0]  m_pd  [2];
  logic [27:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [27:0] model_out();
    return {m_act[0] ^ 12'h800, m_act[1] ^ 12'h800, m_pd[0], m_pd[1]};
  endfunction

  task automatic compare(input logic [27:0] e, input string tag);
    logic [27:0] o;
    o = {code_a, code_b, pdm_a, pdm_b};
    n_vec++;
    if (o !== e) begin
      n_bad++;
      $display("FAIL %s: got a=%h b=%h pa=%b pb=%b expected a=%h b=%h pa=%b pb=%b",
               tag, o[27:16], o[15:4], o[3:2], o[1:0], e[27:16], e[15:4], e[3:2], e[1:0]);
    end
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic model_zero();
    for (int i = 0; i < 2; i++) begin
      m_stg[i] = '0; m_act[i] = '0; m_pd[i] = 2'b00;
    end
  endtask

  task automatic model_apply(input logic [15:0] w);
    logic [1:0] op, imp;
    logic sel;
    op = w[15:14]; sel = w[13];
    if (w[12]) begin
      imp = (w[11:10] == 2'b01) ? 2'b01 : (w[11:10] == 2'b10) ? 2'b10 : 2'b11;
      if (op != 2'b10) m_pd[0] = imp;
      if (op != 2'b01) m_pd[1] = imp;
    end else begin
      case (op)
        2'b00: m_stg[sel] = w[11:0];
        2'b01: begin m_stg[sel] = w[11:0]; m_act[sel] = w[11:0]; m_pd[sel] = 2'b00; end
        2'b10: begin
          m_stg[sel] = w[11:0]; m_act[sel] = w[11:0]; m_pd[sel] = 2'b00;
          m_act[!sel] = m_stg[!sel]; m_pd[!sel] = 2'b00;
        end
        default: begin
          for (int i = 0; i < 2; i++) begin
            if (!sel) begin m_stg[i] = w[11:0]; m_act[i] = w[11:0]; end
            else m_act[i] = m_stg[i];
            m_pd[i] = 2'b00;
          end
        end
      endcase
    end
  endtask

  task automatic cmd(input logic [15:0] w, input string tag);
    @(negedge clk);
    word = w; load = 1'b1;
    @(posedge clk);
    #1 load = 1'b0; word = ~w;
    model_apply(w);
    exp_q.push_back(model_out()); tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    @(posedge clk);
    #1;
    exp_q.push_back(model_out()); tag_q.push_back(tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    model_zero();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(model_out(), "R1 reset state");
    rst_n = 1'b1;
    idle("R1 after reset release");

    cmd(16'h0123, "R2 stage A only");
    cmd(16'h2456, "R2 stage B only");
    cmd(16'hE000, "R5 transfer both");
    cmd(16'h47FF, "R3 update A full scale");
    cmd(16'h6800, "R3 update B zero");
    cmd(16'h0AAA, "R2 stage A");
    cmd(16'h2555, "R2 stage B");
    cmd(16'h8001, "R4 update A, B from staging");
    cmd(16'hA3C3, "R4 update B, A from staging");
    cmd(16'hC9AB, "R5 write both");

    for (int t = 0; t < 4; t++)
      for (int m = 0; m < 4; m++)
        cmd({2'(t), 1'(m), 1'b1, 2'(m), 10'h155}, "R6 power-down row");

    cmd(16'h1000, "R6 all hi-Z");
    cmd(16'h0111, "R7 stage A keeps power-down");
    cmd(16'h4222, "R7 update A wakes A only");
    cmd(16'h1400, "R6 all 1k");
    cmd(16'h2333, "R7 stage B keeps power-down");
    cmd(16'hE000, "R7 transfer wakes both");
    cmd(16'h9800, "R6 B 100k");
    cmd(16'h0444, "R2 stage A before clear");

    @(negedge clk);
    clr_n = 1'b0;
    #2;
    model_zero();
    compare(model_out(), "R8 clear without clock edge");
    @(posedge clk);
    #1;
    exp_q.push_back(model_out()); tag_q.push_back("R8 clear held");
    @(negedge clk);
    #1 clr_n = 1'b1;
    idle("R9 hold after clear release");
    idle("R9 hold second idle");
    cmd(16'hE000, "R8 staging cleared, transfer gives midscale");
    cmd(16'h4FFF, "R3 update A after clear");
    idle("R9 hold without strobe");

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule